// File: doc/BRIEF.md
# Selectable-Ratio Reference Divider

This block divides an incoming reference clock by one of nine fixed integer ratios and hands a one-cycle pulse to a downstream phase comparator once per division period. Two selector inputs pick the ratio. Each selector carries a three-level setting encoded in two bits, so the pair gives nine combinations, each mapped to one ratio from a fixed, non-contiguous set. Several ratios in the set are the base ratio plus one. Choosing one of these moves the comparison frequency slightly, which keeps its harmonics away from a sensitive receive band.

The block reports the ratio it is currently dividing by. It also drives a roughly half-duty square wave with the same period, which a test monitor can observe. A new selector setting never cuts a period short. The counter finishes the running period with the old ratio and only then reloads with the new one.

Top module: `refdiv_top`

## Requirements
- R1: Each selector level is decoded as 2'b00 = low, 2'b01 = high, 2'b10 = mid. With the pair written (sel_a, sel_b), the ratios are: (low,low)=32, (low,high)=33, (low,mid)=36, (high,low)=48, (high,high)=49, (high,mid)=35, (mid,low)=64, (mid,high)=65, (mid,mid)=63.
- R2: A selector code of 2'b11 selects exactly the same ratio as 2'b10 (mid).
- R3: `pulse_o` is high for exactly one clock per division period. Consecutive pulses are exactly N clocks apart, where N is the ratio shown on `ratio_o` during the earlier pulse.
- R4: A change on the selectors takes effect only at the wrap. `ratio_o` changes only in a cycle where `pulse_o` is high, and it then shows the selection sampled at that wrap. A running period is never shortened or lengthened by a selector change.
- R5: In a period of ratio N, `square_o` is high for ceil(N/2) clocks starting with the pulse cycle, and low for the rest of the period.
- R6: While `rst_i` is high at a clock edge, the block loads the selected ratio: `ratio_o` shows it and `pulse_o` and `square_o` are low. The first pulse comes N clocks after the last reset edge, and `square_o` stays low until that pulse.
- R7: `ratio_o` always holds one of the nine supported ratios once reset has been applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock to divide |
| rst_i | input | 1 | Synchronous active-high reset |
| sel_a_i | input | 2 | First ratio selector level |
| sel_b_i | input | 2 | Second ratio selector level |
| pulse_o | output | 1 | One-clock pulse per division period |
| square_o | output | 1 | Near half-duty square wave of the divided clock |
| ratio_o | output | 7 | Division ratio currently in effect |

## Verification
The bench visits all nine selector combinations and measures each period edge to edge, so a wrong table entry or an off-by-one reload shows up as a period one clock too long or too short. It repeats the mid setting with code 2'b11. A decoder that treated that code as low or high would pick a different ratio. The bench also switches from the longest ratio to the shortest one partway through a period. A design that reloaded at once would cut that period short, and one that latched the ratio late would hold the old period one wrap too long. Odd ratios test the square wave's high time, since a rounding error there leaves it high one clock too long or too short.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    localparam int RATIO_W = 7;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_HIGH = 2'b01,
        LVL_MID  = 2'b10
    } lvl_e;

    // Code 2'b11 folds onto the mid level.
    function automatic lvl_e to_level(input logic [1:0] code);
        case (code)
            2'b00:   return LVL_LOW;
            2'b01:   return LVL_HIGH;
            default: return LVL_MID;
        endcase
    endfunction

    function automatic logic [RATIO_W-1:0] ratio_lookup(input lvl_e a, input lvl_e b);
        case ({a, b})
            {LVL_LOW,  LVL_LOW }: return RATIO_W'(32);
            {LVL_LOW,  LVL_HIGH}: return RATIO_W'(33);
            {LVL_LOW,  LVL_MID }: return RATIO_W'(36);
            {LVL_HIGH, LVL_LOW }: return RATIO_W'(48);
            {LVL_HIGH, LVL_HIGH}: return RATIO_W'(49);
            {LVL_HIGH, LVL_MID }: return RATIO_W'(35);
            {LVL_MID,  LVL_LOW }: return RATIO_W'(64);
            {LVL_MID,  LVL_HIGH}: return RATIO_W'(65);
            {LVL_MID,  LVL_MID }: return RATIO_W'(63);
            default:              return RATIO_W'(32);
        endcase
    endfunction

    function automatic logic ratio_legal(input logic [RATIO_W-1:0] r);
        return r inside {RATIO_W'(32), RATIO_W'(33), RATIO_W'(35), RATIO_W'(36),
                         RATIO_W'(48), RATIO_W'(49), RATIO_W'(63), RATIO_W'(64),
                         RATIO_W'(65)};
    endfunction

    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
        logic [RATIO_W-1:0] ratio;
    } cnt_state_t;

    typedef struct packed {
        logic pulse;
        logic square;
    } out_state_t;

endpackage

// File: rtl/refdiv_decode.sv
module refdiv_decode
    import refdiv_pkg::*;
#(
    parameter int NUM_SEL = 2,
    parameter int W       = RATIO_W
) (
    input  logic [NUM_SEL*2-1:0] sel_codes_i,
    output logic [W-1:0]         ratio_o
);

    lvl_e level [NUM_SEL];

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_level
        always_comb level[g] = to_level(sel_codes_i[g*2 +: 2]);
    end

    always_comb begin
        ratio_o = W'(ratio_lookup(level[NUM_SEL-1], level[0]));
        assert_decode_legal_R1: assert (ratio_legal(RATIO_W'(ratio_o)));
    end

endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter
    import refdiv_pkg::*;
#(
    parameter int W = RATIO_W
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] ratio_sel_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] ratio_o,
    output logic         wrap_o
);

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        wrap_o  = (state_q.cnt == '0);
        if (rst_i || wrap_o) begin
            state_d.cnt   = ratio_sel_i - W'(1);
            state_d.ratio = ratio_sel_i;
        end else begin
            state_d.cnt = state_q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    assign cnt_o   = state_q.cnt;
    assign ratio_o = state_q.ratio;

    assert_reload_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap_o |=> (cnt_o == $past(ratio_sel_i) - W'(1)));

    assert_count_down_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        !wrap_o |=> (cnt_o == $past(cnt_o) - W'(1)));

    assert_ratio_legal_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        ratio_legal(RATIO_W'(ratio_o)));

endmodule

// File: rtl/refdiv_outstage.sv
module refdiv_outstage
    import refdiv_pkg::*;
#(
    parameter int W = RATIO_W
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         wrap_i,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] ratio_i,
    output logic         pulse_o,
    output logic         square_o
);

    out_state_t out_d, out_q;

    always_comb begin
        out_d = out_q;
        if (rst_i) begin
            out_d.pulse  = 1'b0;
            out_d.square = 1'b0;
        end else begin
            out_d.pulse = wrap_i;
            if (wrap_i) begin
                out_d.square = 1'b1;
            end else if (cnt_i == (ratio_i >> 1)) begin
                out_d.square = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        out_q <= out_d;
    end

    assign pulse_o  = out_q.pulse;
    assign square_o = out_q.square;

    assert_pulse_single_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |=> !pulse_o);

    assert_square_rise_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(square_o) |-> pulse_o);

endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
    import refdiv_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [1:0]         sel_a_i,
    input  logic [1:0]         sel_b_i,
    output logic               pulse_o,
    output logic               square_o,
    output logic [RATIO_W-1:0] ratio_o
);

    localparam int NUM_SEL = 2;

    logic [RATIO_W-1:0] ratio_sel;
    logic [RATIO_W-1:0] cnt;
    logic               wrap;

    refdiv_decode #(.NUM_SEL(NUM_SEL), .W(RATIO_W)) i_decode (
        .sel_codes_i ({sel_a_i, sel_b_i}),
        .ratio_o     (ratio_sel)
    );

    refdiv_counter #(.W(RATIO_W)) i_counter (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .ratio_sel_i (ratio_sel),
        .cnt_o       (cnt),
        .ratio_o     (ratio_o),
        .wrap_o      (wrap)
    );

    refdiv_outstage #(.W(RATIO_W)) i_outstage (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .wrap_i   (wrap),
        .cnt_i    (cnt),
        .ratio_i  (ratio_o),
        .pulse_o  (pulse_o),
        .square_o (square_o)
    );

    assert_ratio_stable_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (!pulse_o && !$past(rst_i)) |-> $stable(ratio_o));

endmodule

// File: tb/test_refdiv_top.sv
module test_refdiv_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] sel_a, sel_b;
    logic       pulse;
    logic       square;
    logic [6:0] ratio;

    int n_checks = 0;
    int n_errors = 0;
    bit model_on = 1'b0;

    always #10 clk = ~clk;

    refdiv_top i_refdiv_top (
        .clk_i    (clk),
        .rst_i    (rst),
        .sel_a_i  (sel_a),
        .sel_b_i  (sel_b),
        .pulse_o  (pulse),
        .square_o (square),
        .ratio_o  (ratio)
    );

    function automatic int level_of(input logic [1:0] c);
        if (c == 2'b00) return 0;
        if (c == 2'b01) return 1;
        return 2;
    endfunction

    function automatic int expected_ratio(input logic [1:0] a, input logic [1:0] b);
        int tbl [9] = '{32, 33, 36, 48, 49, 35, 64, 65, 63};
        return tbl[level_of(a) * 3 + level_of(b)];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model, updated on every rising edge.
    int m_until, m_ratio, m_k;
    bit m_first, m_pulse, m_sq;

    always @(posedge clk) begin
        if (rst) begin
            m_ratio = expected_ratio(sel_a, sel_b);
            m_until = m_ratio;
            m_first = 1'b1;
            m_pulse = 1'b0;
            m_sq    = 1'b0;
            m_k     = 0;
            model_on = 1'b1;
        end else if (model_on) begin
            m_until--;
            if (m_until == 0) begin
                m_ratio = expected_ratio(sel_a, sel_b);
                m_until = m_ratio;
                m_pulse = 1'b1;
                m_k     = 0;
                m_first = 1'b0;
                m_sq    = 1'b1;
            end else begin
                m_pulse = 1'b0;
                m_k++;
                m_sq = !m_first && (m_k < (m_ratio + 1) / 2);
            end
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            check(pulse == m_pulse, "R3 pulse", int'(pulse), int'(m_pulse));
            check(ratio == 7'(m_ratio), "R4 ratio", int'(ratio), m_ratio);
            check(square == m_sq, "R5 square", int'(square), int'(m_sq));
        end
    end

    task automatic wait_pulse();
        do @(negedge clk); while (!pulse);
    endtask

    // Starting at a pulse, count clocks to the next pulse.
    task automatic period_after_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!pulse && n < 200);
    endtask

    task automatic run_combo(input logic [1:0] a, input logic [1:0] b, input int exp, input string req);
        int n;
        sel_a = a;
        sel_b = b;
        wait_pulse();
        check(ratio == 7'(exp), req, int'(ratio), exp);
        period_after_pulse(n);
        check(n == exp, req, n, exp);
    endtask

    initial begin
        #2_000_000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int n;
        rst   = 1'b1;
        sel_a = 2'b00;
        sel_b = 2'b00;
        repeat (3) @(negedge clk);
        // R6: reset state
        check(pulse == 1'b0, "R6 reset pulse", int'(pulse), 0);
        check(square == 1'b0, "R6 reset square", int'(square), 0);
        check(ratio == 7'd32, "R6 reset ratio", int'(ratio), 32);
        rst = 1'b0;
        // R6: first pulse 32 clocks after the last reset edge
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!pulse && n < 200);
        check(n == 32, "R6 first pulse delay", n, 32);

        // R1: every combination of the table
        run_combo(2'b00, 2'b01, 33, "R1 low/high");
        run_combo(2'b00, 2'b10, 36, "R1 low/mid");
        run_combo(2'b01, 2'b00, 48, "R1 high/low");
        run_combo(2'b01, 2'b01, 49, "R1 high/high");
        run_combo(2'b01, 2'b10, 35, "R1 high/mid");
        run_combo(2'b10, 2'b00, 64, "R1 mid/low");
        run_combo(2'b10, 2'b01, 65, "R1 mid/high");
        run_combo(2'b10, 2'b10, 63, "R1 mid/mid");
        run_combo(2'b00, 2'b00, 32, "R1 low/low");

        // R2: code 2'b11 behaves as mid
        run_combo(2'b11, 2'b01, 65, "R2 a=11");
        run_combo(2'b00, 2'b11, 36, "R2 b=11");
        run_combo(2'b11, 2'b11, 63, "R2 both 11");

        // R4: switch from 65 to 32 partway through a period
        run_combo(2'b10, 2'b01, 65, "R4 setup");
        wait_pulse();
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 10) begin
                sel_a = 2'b00;
                sel_b = 2'b00;
            end
            if (n > 10 && !pulse)
                check(ratio == 7'd65, "R4 ratio held", int'(ratio), 65);
        end while (!pulse && n < 200);
        check(n == 65, "R4 period not shortened", n, 65);
        check(ratio == 7'd32, "R4 new ratio at wrap", int'(ratio), 32);
        period_after_pulse(n);
        check(n == 32, "R4 new period", n, 32);

        // R7: value remains legal after activity
        check(ratio inside {7'd32, 7'd33, 7'd35, 7'd36, 7'd48, 7'd49, 7'd63, 7'd64, 7'd65},
              "R7 legal ratio", int'(ratio), 32);

        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule